// File: doc/BRIEF.md
# Boot Script Sequencer

This block lets a chip configure itself out of reset with no host processor. It reads a compact byte-coded program one byte at a time from external serial flash through an address/byte request-response port. It decodes each instruction and issues the resulting register accesses on a simple internal register bus. Its instructions are no-operation, register command and data writes, status and data reads, attribute fetches, repeat-counter loads, jumps and a decrement-and-jump loop. When the program ends, the sequencer drops its busy output and hands the device over to the host.

The program is one-byte opcodes, each followed by zero, one or four operand bytes. Flash addresses are 24 bits wide after reset. The program can widen them to the full 32 bits and narrow them again. A strap input, sampled while reset is held, decides whether the sequencer runs at all. The flash protocol engine and the register-bus target sit outside this block.

Top module: `boot_seq`

## Requirements
- R1: The value of `boot_strap` on the last clock edge with `rst_n` low decides whether the sequencer runs. When it is 0, `busy` is 0, `host_owns` is 1, `err` is 0, and `fetch_req` and `rb_valid` stay 0 from the first cycle after reset.
- R2: When the strap is 1, the first fetch is at `START_ADDR`. Each accepted byte (`fetch_req` and `fetch_ack` both high) advances the fetch address by one. `fetch_req` and `fetch_addr` hold steady until the byte is accepted.
- R3: Opcode 8'h00 or 8'hFF ends the program: `busy` falls, `host_owns` rises, and no fetch or bus request follows. Opcode 8'hAA only moves on to the next byte.
- R4: Each of opcodes 10h, 11h, 12h, 13h and 30h takes one operand byte. It then raises `rb_valid` with `rb_data` equal to that operand and `rb_op` set as follows: 10h gives 0 (status read), 11h gives 1 (command write), 12h gives 2 (data read), 13h gives 3 (data write), 30h gives 4 (attribute fetch). `rb_valid`, `rb_op` and `rb_data` hold until `rb_ready`, and only then is the next opcode fetched. A fetch and a bus request are never active in the same cycle.
- R5: Opcode 20h loads its operand byte into the repeat counter and makes no bus access.
- R6: Opcode 80h jumps to the address in its four operand bytes, most significant byte first. Opcode 81h decrements the repeat counter, wrapping modulo 2^RPT_W. It jumps when the result is nonzero and otherwise continues at the byte after the instruction.
- R7: After reset the address mode is narrow, and jump targets and address increments keep only the low 24 bits. Opcode B7h selects the wide mode, in which all 32 bits are used. Opcode E9h returns to narrow mode and clears the upper byte of the next fetch address. In narrow mode no fetch address has a nonzero upper byte.
- R8: Any opcode not listed above ends the program as in R3 and sets `err`. `err` stays set until reset.
- R9: With the strap at 1, `busy` is high from reset release until the ending opcode is accepted, and `host_owns` is always its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap | input | 1 | Run-enable strap, sampled while in reset |
| fetch_req | output | 1 | Flash byte request |
| fetch_addr | output | 32 | Flash byte address |
| fetch_ack | input | 1 | Byte accepted; `fetch_data` valid this cycle |
| fetch_data | input | 8 | Flash byte |
| rb_valid | output | 1 | Register-bus request |
| rb_op | output | 3 | Register-bus operation code (R4) |
| rb_data | output | 8 | Register-bus operand byte |
| rb_ready | input | 1 | Register-bus target accepts the request |
| busy | output | 1 | Sequencer owns the device |
| host_owns | output | 1 | Host owns the device |
| err | output | 1 | Undefined opcode seen |

## Verification
The assertions assume that the flash side raises `fetch_ack` only while `fetch_req` is high, and the bus side raises `rb_ready` only while `rb_valid` is high. The narrow-mode address check further assumes that `START_ADDR` lies below 2^24. The bench keeps to these assumptions by deriving both acknowledges, at the falling edge, from the request it sees at that moment. It spaces the acknowledges with a per-program gap, so that the hold-until-accepted behaviour is exercised both back-to-back and with waits, and it leaves the start address at its default.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_ARG  = 2'd1,
    ST_BUS  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    BOP_STAT_RD = 3'd0,
    BOP_CMD_WR  = 3'd1,
    BOP_DAT_RD  = 3'd2,
    BOP_DAT_WR  = 3'd3,
    BOP_ATTR    = 3'd4
  } bus_op_t;

  typedef enum logic [3:0] {
    K_EXIT, K_NOP, K_WIDE_ON, K_WIDE_OFF, K_BUS,
    K_LOADRPT, K_JMP, K_DJNZ, K_BAD
  } op_kind_t;

  // Map an opcode byte to its instruction class.
  function automatic op_kind_t classify(input logic [7:0] b);
    case (b)
      8'h00, 8'hFF:                      return K_EXIT;
      8'hAA:                             return K_NOP;
      8'hB7:                             return K_WIDE_ON;
      8'hE9:                             return K_WIDE_OFF;
      8'h10, 8'h11, 8'h12, 8'h13, 8'h30: return K_BUS;
      8'h20:                             return K_LOADRPT;
      8'h80:                             return K_JMP;
      8'h81:                             return K_DJNZ;
      default:                           return K_BAD;
    endcase
  endfunction

  // Operand bytes that follow an opcode of the given class.
  function automatic logic [2:0] arg_len(input op_kind_t k);
    case (k)
      K_BUS, K_LOADRPT: return 3'd1;
      K_JMP, K_DJNZ:    return 3'd4;
      default:          return 3'd0;
    endcase
  endfunction

  // Register-bus operation carried out by a bus-class opcode.
  function automatic bus_op_t bus_op_of(input logic [7:0] b);
    case (b)
      8'h10:   return BOP_STAT_RD;
      8'h11:   return BOP_CMD_WR;
      8'h12:   return BOP_DAT_RD;
      8'h13:   return BOP_DAT_WR;
      default: return BOP_ATTR;
    endcase
  endfunction

endpackage

// File: rtl/bseq_pc.sv
module bseq_pc #(
  parameter int ADDR_W = 32,
  parameter int NARROW_W = 24,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wide_nxt,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] NARROW_MASK =
    {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  // Apply the address mode that holds after this cycle.
  function automatic logic [ADDR_W-1:0] fit(input logic [ADDR_W-1:0] a,
                                            input logic w);
    return w ? a : (a & NARROW_MASK);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      pc <= START_ADDR;
    else if (load)   pc <= fit(load_addr, wide_nxt);
    else if (step)   pc <= fit(pc + 1'b1, wide_nxt);
  end
endmodule

// File: rtl/bseq_rpt.sv
module bseq_rpt #(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RPT_W-1:0] ld_val,
  input  logic             dec,
  output logic [RPT_W-1:0] cnt,
  output logic             dec_nz
);
  localparam logic [RPT_W-1:0] ONE = RPT_W'(1);

  function automatic logic [RPT_W-1:0] less_one(input logic [RPT_W-1:0] v);
    return v - ONE;
  endfunction

  assign dec_nz = (less_one(cnt) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= ld_val;
    else if (dec)  cnt <= less_one(cnt);
  end
endmodule

// File: rtl/bseq_argbuf.sv
module bseq_argbuf #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        len,
  input  logic              shift,
  input  logic [7:0]        din,
  output logic              last,
  output logic [ADDR_W-1:0] word_in
);
  logic [2:0]        rem;
  logic [ADDR_W-1:0] word;

  assign last    = (rem == 3'd1);
  assign word_in = {word[ADDR_W-9:0], din};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      word <= '0;
    end else if (start) begin
      rem  <= len;
      word <= '0;
    end else if (shift) begin
      rem  <= rem - 3'd1;
      word <= word_in;
    end
  end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NARROW_W = 24,
  parameter int RPT_W = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_strap,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [7:0]        fetch_data,
  output logic              rb_valid,
  output logic [2:0]        rb_op,
  output logic [7:0]        rb_data,
  input  logic              rb_ready,
  output logic              busy,
  output logic              host_owns,
  output logic              err
);
  seq_state_t  state;
  op_kind_t    kind_q;
  op_kind_t    kind_now;
  logic [7:0]  opc_q;
  logic [7:0]  rb_data_q;
  logic        addr_wide;
  logic        wide_nxt;

  // Named internal events
  logic fetch_fire, op_fire, arg_fire, arg_done, bus_fire;
  logic arg_last, jump_take, rpt_load, rpt_dec, rpt_nz, arg_start;
  logic [ADDR_W-1:0] arg_word;
  logic [RPT_W-1:0]  rpt_cnt;

  assign kind_now   = classify(fetch_data);
  assign fetch_req  = (state == ST_OPC) || (state == ST_ARG);
  assign rb_valid   = (state == ST_BUS);
  assign rb_op      = bus_op_of(opc_q);
  assign rb_data    = rb_data_q;
  assign busy       = (state != ST_DONE);
  assign host_owns  = ~busy;

  assign fetch_fire = fetch_req & fetch_ack;
  assign op_fire    = fetch_fire & (state == ST_OPC);
  assign arg_fire   = fetch_fire & (state == ST_ARG);
  assign arg_done   = arg_fire & arg_last;
  assign bus_fire   = rb_valid & rb_ready;
  assign arg_start  = op_fire & (arg_len(kind_now) != 3'd0);
  assign rpt_load   = arg_done & (kind_q == K_LOADRPT);
  assign rpt_dec    = arg_done & (kind_q == K_DJNZ);
  assign jump_take  = arg_done & ((kind_q == K_JMP) ||
                                  ((kind_q == K_DJNZ) && rpt_nz));

  always_comb begin
    wide_nxt = addr_wide;
    if (op_fire && kind_now == K_WIDE_ON)  wide_nxt = 1'b1;
    if (op_fire && kind_now == K_WIDE_OFF) wide_nxt = 1'b0;
  end

  bseq_pc #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .START_ADDR(START_ADDR)) u_pc (
    .clk(clk), .rst_n(rst_n), .step(fetch_fire), .load(jump_take),
    .load_addr(arg_word), .wide_nxt(wide_nxt), .pc(fetch_addr)
  );

  bseq_rpt #(.RPT_W(RPT_W)) u_rpt (
    .clk(clk), .rst_n(rst_n), .load(rpt_load), .ld_val(RPT_W'(fetch_data)),
    .dec(rpt_dec), .cnt(rpt_cnt), .dec_nz(rpt_nz)
  );

  bseq_argbuf #(.ADDR_W(ADDR_W)) u_arg (
    .clk(clk), .rst_n(rst_n), .start(arg_start), .len(arg_len(kind_now)),
    .shift(arg_fire), .din(fetch_data), .last(arg_last), .word_in(arg_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= boot_strap ? ST_OPC : ST_DONE;
      kind_q    <= K_NOP;
      opc_q     <= '0;
      rb_data_q <= '0;
      addr_wide <= 1'b0;
      err       <= 1'b0;
    end else begin
      addr_wide <= wide_nxt;
      case (state)
        ST_OPC: if (op_fire) begin
          opc_q  <= fetch_data;
          kind_q <= kind_now;
          case (kind_now)
            K_EXIT: state <= ST_DONE;
            K_BAD: begin
              state <= ST_DONE;
              err   <= 1'b1;
            end
            K_BUS, K_LOADRPT, K_JMP, K_DJNZ: state <= ST_ARG;
            default: state <= ST_OPC;
          endcase
        end
        ST_ARG: if (arg_done) begin
          if (kind_q == K_BUS) begin
            state     <= ST_BUS;
            rb_data_q <= fetch_data;
          end else begin
            state <= ST_OPC;
          end
        end
        ST_BUS: if (bus_fire) state <= ST_OPC;
        default: state <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int NARROW_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              host_owns,
  input logic              err,
  input logic              fetch_req,
  input logic              fetch_ack,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              rb_valid,
  input logic              rb_ready,
  input logic [2:0]        rb_op,
  input logic [7:0]        rb_data,
  input logic              wide
);
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr)); // R2
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && !rb_ready |=> rb_valid && $stable(rb_op) && $stable(rb_data)); // R4
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && rb_valid)); // R4
  AST_OP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> rb_op <= 3'd4); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fetch_req && !rb_valid); // R3
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy); // R9
  AST_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    host_owns != busy); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R8
  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !wide |-> (fetch_addr >> NARROW_W) == '0); // R7
endmodule

bind boot_seq boot_seq_chk #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .host_owns(host_owns), .err(err),
  .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr),
  .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_op(rb_op), .rb_data(rb_data),
  .wide(addr_wide)
);

// File: tb/boot_seq_test.sv
module boot_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_strap = 1'b0;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_ack = 1'b0;
  logic [7:0]  fetch_data = 8'h00;
  logic        rb_valid;
  logic [2:0]  rb_op;
  logic [7:0]  rb_data;
  logic        rb_ready = 1'b0;
  logic        busy, host_owns, err;

  always #2 clk = ~clk;

  boot_seq uut (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .rb_valid(rb_valid), .rb_op(rb_op),
    .rb_data(rb_data), .rb_ready(rb_ready), .busy(busy),
    .host_owns(host_owns), .err(err)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, bus_seen = 0;
  int fetch_gap = 1, rb_gap = 1;
  bit [7:0] flash [int unsigned];

  // Behavioural reference: 0 opcode, 1 operand, 2 bus, 3 done
  int          m_state = 3, m_need = 0;
  bit          m_wide = 0, m_err = 0;
  logic [31:0] m_pc = 0, m_arg = 0;
  logic [7:0]  m_op = 0, m_bdata = 0, m_rpt = 0;

  function automatic logic [7:0] rd(input logic [31:0] a);
    return flash.exists(a) ? flash[a] : 8'h00;
  endfunction
  function automatic logic [31:0] clip(input logic [31:0] a, input bit w);
    return w ? a : {8'h00, a[23:0]};
  endfunction
  function automatic logic [2:0] exp_op(input logic [7:0] o);
    if (o == 8'h10) return 3'd0;
    if (o == 8'h11) return 3'd1;
    if (o == 8'h12) return 3'd2;
    if (o == 8'h13) return 3'd3;
    return 3'd4;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = boot_strap ? 0 : 3;
      m_pc = 0; m_wide = 0; m_err = 0; m_rpt = 0; m_need = 0;
    end else begin
      if (rb_valid && rb_ready) bus_seen++;
      if (m_state < 2 && fetch_ack) begin
        logic [7:0] b;
        b = rd(m_pc);
        if (m_state == 0) begin
          m_op = b;
          if (b == 8'h00 || b == 8'hFF) m_state = 3;
          else if (b == 8'hAA) m_state = 0;
          else if (b == 8'hB7) m_wide = 1;
          else if (b == 8'hE9) m_wide = 0;
          else if (b == 8'h10 || b == 8'h11 || b == 8'h12 || b == 8'h13 ||
                   b == 8'h30 || b == 8'h20) begin m_state = 1; m_need = 1; m_arg = 0; end
          else if (b == 8'h80 || b == 8'h81) begin m_state = 1; m_need = 4; m_arg = 0; end
          else begin m_state = 3; m_err = 1; end
          m_pc = clip(m_pc + 1, m_wide);
        end else begin
          m_pc = clip(m_pc + 1, m_wide);
          m_arg = {m_arg[23:0], b};
          m_need--;
          if (m_need == 0) begin
            m_state = 0;
            if (m_op == 8'h20) m_rpt = b;
            else if (m_op == 8'h80) m_pc = clip(m_arg, m_wide);
            else if (m_op == 8'h81) begin
              m_rpt = m_rpt - 8'd1;
              if (m_rpt != 0) m_pc = clip(m_arg, m_wide);
            end else begin m_state = 2; m_bdata = b; end
          end
        end
      end else if (m_state == 2 && rb_ready) m_state = 0;
    end
  end

  // Compare against the model, then drive the responders
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R9", "busy", {31'd0, busy}, {31'd0, m_state != 3});
      chk("R3", "host_owns", {31'd0, host_owns}, {31'd0, m_state == 3});
      chk("R2", "fetch_req", {31'd0, fetch_req}, {31'd0, m_state < 2});
      if (m_state < 2) chk(m_wide ? "R7" : "R2", "fetch_addr", fetch_addr, m_pc);
      chk("R4", "rb_valid", {31'd0, rb_valid}, {31'd0, m_state == 2});
      if (m_state == 2) begin
        chk("R4", "rb_op", {29'd0, rb_op}, {29'd0, exp_op(m_op)});
        chk("R4", "rb_data", {24'd0, rb_data}, {24'd0, m_bdata});
      end
      chk("R8", "err", {31'd0, err}, {31'd0, m_err});
    end
    fetch_ack  = rst_n && fetch_req && (cyc % fetch_gap == 0);
    fetch_data = rd(fetch_addr);
    rb_ready   = rst_n && rb_valid && (cyc % rb_gap == 0);
  end

  task automatic run(input bit strap, input int fg, input int rg,
                     input bit exp_err, input int exp_bus, input string tag);
    int t;
    @(negedge clk); #1;
    rst_n = 1'b0; boot_strap = strap; fetch_gap = fg; rb_gap = rg;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1; bus_seen = 0;
    @(negedge clk); #1;
    chk(strap ? "R9" : "R1", {tag, " busy after reset"}, {31'd0, busy}, {31'd0, strap});
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); #1; t++; end
    if (t >= 5000) begin n_cmp++; n_bad++; $display("FAIL R9 %s timeout: actual busy expected idle", tag); end
    repeat (4) @(negedge clk);
    #1;
    chk("R3", {tag, " host_owns"}, {31'd0, host_owns}, 32'd1);
    chk("R8", {tag, " err"}, {31'd0, err}, {31'd0, exp_err});
    chk("R4", {tag, " bus count"}, bus_seen, exp_bus);
  endtask

  initial begin
    // R1: strap low, program never runs
    flash.delete();
    flash[0] = 8'h13; flash[1] = 8'h01; flash[2] = 8'h00;
    run(1'b0, 1, 1, 1'b0, 0, "R1 strap low");
    // R3 R4: nop and every bus operation, slow responders
    flash.delete();
    flash[0] = 8'hAA; flash[1] = 8'h11; flash[2] = 8'h5A; flash[3] = 8'h13;
    flash[4] = 8'h33; flash[5] = 8'h10; flash[6] = 8'h01; flash[7] = 8'h12;
    flash[8] = 8'h02; flash[9] = 8'h30; flash[10] = 8'h07; flash[11] = 8'h00;
    run(1'b1, 2, 3, 1'b0, 5, "R4 bus ops");
    // R5 R6: loop three times, then counter 1 falls through
    flash.delete();
    flash[0] = 8'h20; flash[1] = 8'h03; flash[2] = 8'h13; flash[3] = 8'hAA;
    flash[4] = 8'h81; flash[5] = 8'h00; flash[6] = 8'h00; flash[7] = 8'h00;
    flash[8] = 8'h02; flash[9] = 8'h20; flash[10] = 8'h01; flash[11] = 8'h81;
    flash[12] = 8'h00; flash[13] = 8'h00; flash[14] = 8'h00; flash[15] = 8'h02;
    flash[16] = 8'h13; flash[17] = 8'hBB; flash[18] = 8'hFF;
    run(1'b1, 1, 1, 1'b0, 4, "R6 djnz loop");
    // R7: wide jumps, then narrow jump drops the upper byte
    flash.delete();
    flash[0] = 8'hB7; flash[1] = 8'h80; flash[2] = 8'h01; flash[3] = 8'h00;
    flash[4] = 8'h00; flash[5] = 8'h10;
    flash[32'h01000010] = 8'h13; flash[32'h01000011] = 8'h44;
    flash[32'h01000012] = 8'h80; flash[32'h01000013] = 8'h00;
    flash[32'h01000014] = 8'h00; flash[32'h01000015] = 8'h00;
    flash[32'h01000016] = 8'h20;
    flash[32'h20] = 8'hE9; flash[32'h21] = 8'h80; flash[32'h22] = 8'h12;
    flash[32'h23] = 8'h00; flash[32'h24] = 8'h00; flash[32'h25] = 8'h30;
    flash[32'h30] = 8'h11; flash[32'h31] = 8'h66; flash[32'h32] = 8'h00;
    flash[32'h12000030] = 8'h13; flash[32'h12000031] = 8'h99;
    run(1'b1, 1, 2, 1'b0, 2, "R7 wide jumps");
    // R7: leaving wide mode truncates the next fetch address
    flash.delete();
    flash[0] = 8'hB7; flash[1] = 8'h80; flash[2] = 8'h02; flash[3] = 8'h00;
    flash[4] = 8'h00; flash[5] = 8'h40;
    flash[32'h02000040] = 8'hE9;
    flash[32'h02000041] = 8'h11; flash[32'h02000042] = 8'h55;
    flash[32'h41] = 8'h13; flash[32'h42] = 8'h77; flash[32'h43] = 8'h00;
    run(1'b1, 3, 1, 1'b0, 1, "R7 narrow again");
    // R8: undefined opcode
    flash.delete();
    flash[0] = 8'hAA; flash[1] = 8'h11; flash[2] = 8'h01; flash[3] = 8'h55;
    flash[4] = 8'h13; flash[5] = 8'h02;
    run(1'b1, 1, 1, 1'b1, 1, "R8 bad opcode");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #600000;
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule